// File: doc/BRIEF.md
# Byte-Lane Frame Aligner with Loss-of-Alignment Tracking

This block sits on one byte-wide lane of a SONET receive path and sees one byte per clock. It looks for the framing marker, which is the final A1 byte (F6h) followed at once by the first A2 byte (28h). When it finds the marker it locks a frame position counter to it. It then raises a one-clock frame pulse each time the third A2 byte of a frame reaches the data output. The block also reports whether it is out of frame and produces one parity bit per output byte. Bit 7 of every byte is the first bit received on the line, and bit 0 is the last.

The pulse can come from two places, chosen by a static select pin. One choice is the internal alignment counter. The other is an external frame marker input, which is passed through with the same latency as the data. A second static pin chooses what the even parity covers: the data byte alone, or the data byte together with the frame pulse.

Alignment is handled by a three-state machine.
- HUNT: the block is out of frame and searches every byte position for the marker. It goes to LOCK on the marker, which is transition T_ACQUIRE.
- LOCK: the block is in frame with no recent errors. It checks the marker only at the one position the counter predicts. A missed marker moves it to VERIFY, which is transition T_MISS.
- VERIFY: the block is in frame with one or more consecutive misses. A good marker sends it back to LOCK and clears the miss count, which is transition T_RECOVER. Further misses keep it in VERIFY, which is transition T_MISS_AGAIN. The fourth consecutive miss returns it to HUNT, which is transition T_DROP.

Top module: `sonet_lane_framer`

## Requirements
- R1: While reset is asserted, the outputs are: data output 00h, frame pulse 0, parity 0, and out-of-frame 1.
- R2: The data output equals the input byte from one clock earlier, with no change to bit order. Data, pulse, parity and out-of-frame all change on the same rising edge, so each set of values describes the same input byte.
- R3: In HUNT, an F6h byte followed directly by a 28h byte at any position causes acquisition. Out-of-frame goes to 0 in the cycle when that 28h byte is on the data output.
- R4: When the select pin is high (internal mode), the frame pulse is high for exactly one cycle per frame. That cycle is the one in which the byte two positions after the first A2 byte (the third A2) is on the data output. The pulse never appears while out-of-frame is 1.
- R5: When the select pin is low (external mode), the frame pulse equals the external marker input delayed by one clock. This holds whether the block is in frame or out of frame.
- R6: While in frame, the marker is checked only at the predicted position. An F6h/28h pair found anywhere else does not move the alignment or the pulse.
- R7: Four consecutive frames with a missed marker at the predicted position set out-of-frame to 1. The change happens in the cycle when the fourth missed byte is on the data output. Any correct marker before the fourth miss clears the miss count.
- R8: Parity is even. With the parity-select pin low, the parity bit is the XOR of the 8 output data bits. With it high, the frame pulse output is also included in the XOR.
- R9: After the block returns to HUNT, it acquires a marker at a new byte offset, and its pulses then follow that new offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Received byte; bit 7 was received first |
| frame_in | input | 1 | External frame marker, used in external mode |
| fp_sel | input | 1 | Static pulse source select: 1 = internal alignment, 0 = external marker |
| par_sel | input | 1 | Static parity coverage select: 1 = data and pulse, 0 = data only |
| dout | output | 8 | Registered data byte |
| fp_out | output | 1 | Frame pulse |
| oof | output | 1 | Out-of-frame indication |
| par | output | 1 | Even parity bit |

## Verification
The bench feeds the block several kinds of stream, and each one separates a different behaviour:
- Random filler bytes with F6h and 28h removed show that the block stays in HUNT when no marker is present.
- Clean frames that follow a run of A1 bytes check acquisition and the position of the third-A2 pulse.
- A frame carrying a stray F6h/28h pair in its middle shows that only the predicted position is checked.
- Runs of three and then four frames with a corrupted first A2 byte separate recovery from loss of alignment.
- A stream shifted by several filler bytes after the loss shows that the block re-acquires at the new offset.
- The external-marker pass uses marker pulses that have no relation to the frame, and runs them both before and after lock. This separates the two pulse sources and also covers parity over the pulse.

// File: rtl/sonet_fr_pkg.sv
package sonet_fr_pkg;

    // Alignment state of one lane
    typedef enum logic [1:0] {
        FR_HUNT   = 2'd0,
        FR_LOCK   = 2'd1,
        FR_VERIFY = 2'd2
    } fr_state_e;

    localparam logic [7:0] FR_A1_BYTE = 8'hF6;
    localparam logic [7:0] FR_A2_BYTE = 8'h28;

endpackage

// File: rtl/fr_marker_match.sv
// Flags the input cycle in which the trailing A1 bytes are followed
// directly by the leading A2 byte.
module fr_marker_match #(
    parameter int           W     = 8,
    parameter int           HIST  = 1,
    parameter logic [W-1:0] A1VAL = 8'hF6,
    parameter logic [W-1:0] A2VAL = 8'h28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic         hit
);

    logic [W-1:0] hist_q [HIST];

    generate
        for (genvar g = 0; g < HIST; g++) begin : g_hist
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist_q[g] <= '0;
                    else        hist_q[g] <= din;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) hist_q[g] <= '0;
                    else        hist_q[g] <= hist_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        hit = (din == A2VAL);
        for (int i = 0; i < HIST; i++) begin
            hit = hit && (hist_q[i] == A1VAL);
        end
    end

endmodule

// File: rtl/fr_pos_counter.sv
// Byte position within the frame; position 0 is the first A2 byte.
module fr_pos_counter #(
    parameter int FRAME_LEN = 9720,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= POS_W'(1);
        end else if (pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + POS_W'(1);
        end
    end

endmodule

// File: rtl/fr_sync_fsm.sv
// HUNT / LOCK / VERIFY alignment machine with consecutive-miss count.
module fr_sync_fsm
    import sonet_fr_pkg::*;
#(
    parameter int MISS_LIMIT = 4,
    parameter int MISS_W     = $clog2(MISS_LIMIT + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      at_check,
    output logic      load,
    output logic      locked,
    output logic      oof_next
);

    fr_state_e         state_q, state_n;
    logic [MISS_W-1:0] miss_q, miss_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_HUNT;
            miss_q  <= '0;
        end else begin
            state_q <= state_n;
            miss_q  <= miss_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state_q;
        miss_n  = miss_q;
        load    = 1'b0;
        unique case (state_q)
            FR_HUNT: begin
                if (hit) begin                        // T_ACQUIRE
                    state_n = FR_LOCK;
                    miss_n  = '0;
                    load    = 1'b1;
                end
            end
            FR_LOCK: begin
                if (at_check && !hit) begin           // T_MISS
                    miss_n  = MISS_W'(1);
                    state_n = (MISS_LIMIT == 1) ? FR_HUNT : FR_VERIFY;
                end
            end
            FR_VERIFY: begin
                if (at_check) begin
                    if (hit) begin                    // T_RECOVER
                        state_n = FR_LOCK;
                        miss_n  = '0;
                    end else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                        state_n = FR_HUNT;            // T_DROP
                        miss_n  = '0;
                    end else begin                    // T_MISS_AGAIN
                        miss_n  = miss_q + MISS_W'(1);
                    end
                end
            end
            default: begin
                state_n = FR_HUNT;
                miss_n  = '0;
            end
        endcase
    end

    assign locked   = (state_q != FR_HUNT);
    assign oof_next = (state_n == FR_HUNT);

endmodule

// File: rtl/fr_out_stage.sv
// Output register: data, pulse, parity and out-of-frame share one edge.
module fr_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         fp_next,
    input  logic         oof_next,
    input  logic         par_sel,
    output logic [W-1:0] dout,
    output logic         fp_out,
    output logic         oof,
    output logic         par
);

    logic par_next;

    always_comb begin
        par_next = ^din;
        if (par_sel) par_next = par_next ^ fp_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            fp_out <= 1'b0;
            oof    <= 1'b1;
            par    <= 1'b0;
        end else begin
            dout   <= din;
            fp_out <= fp_next;
            oof    <= oof_next;
            par    <= par_next;
        end
    end

endmodule

// File: rtl/sonet_lane_framer.sv
module sonet_lane_framer
    import sonet_fr_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FRAME_LEN  = 9720,
    parameter int A1_HIST    = 1,
    parameter int FP_OFFSET  = 2,
    parameter int MISS_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              frame_in,
    input  logic              fp_sel,
    input  logic              par_sel,
    output logic [DATA_W-1:0] dout,
    output logic              fp_out,
    output logic              oof,
    output logic              par
);

    localparam int POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    logic             hit;
    logic             load;
    logic             locked;
    logic             oof_next;
    logic [POS_W-1:0] pos;
    logic             fp_int_next;
    logic             fp_next;

    fr_marker_match #(
        .W     (DATA_W),
        .HIST  (A1_HIST),
        .A1VAL (DATA_W'(FR_A1_BYTE)),
        .A2VAL (DATA_W'(FR_A2_BYTE))
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .hit   (hit)
    );

    fr_pos_counter #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .pos   (pos)
    );

    fr_sync_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .at_check (pos == '0),
        .load     (load),
        .locked   (locked),
        .oof_next (oof_next)
    );

    assign fp_int_next = locked && (pos == POS_W'(FP_OFFSET));
    assign fp_next     = fp_sel ? fp_int_next : frame_in;

    fr_out_stage #(
        .W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .fp_next  (fp_next),
        .oof_next (oof_next),
        .par_sel  (par_sel),
        .dout     (dout),
        .fp_out   (fp_out),
        .oof      (oof),
        .par      (par)
    );

endmodule

// File: rtl/sonet_lane_framer_chk.sv
module sonet_lane_framer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic              frame_in,
    input logic              fp_sel,
    input logic              par_sel,
    input logic [DATA_W-1:0] dout,
    input logic              fp_out,
    input logic              oof,
    input logic              par
);

    assert_data_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dout == $past(din)));

    assert_acquire_on_a2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> (dout == DATA_W'(8'h28)) && ($past(dout) == DATA_W'(8'hF6)));

    assert_fp_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_sel && fp_out) |=> !fp_out);

    assert_fp_only_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_sel && fp_out) |-> !oof);

    assert_ext_fp_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_sel |=> (fp_out == $past(frame_in)));

    assert_drop_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof) |-> !((dout == DATA_W'(8'h28)) && ($past(dout) == DATA_W'(8'hF6))));

    assert_even_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        par == ((^dout) ^ (par_sel & fp_out)));

endmodule

bind sonet_lane_framer sonet_lane_framer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .frame_in (frame_in),
    .fp_sel   (fp_sel),
    .par_sel  (par_sel),
    .dout     (dout),
    .fp_out   (fp_out),
    .oof      (oof),
    .par      (par)
);

// File: tb/sonet_lane_framer_tb.sv
module sonet_lane_framer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FLEN       = 24;
    localparam logic [7:0] A1 = 8'hF6;
    localparam logic [7:0] A2 = 8'h28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       frame_in = 1'b0;
    logic       fp_sel = 1'b1;
    logic       par_sel = 1'b0;
    logic [7:0] dout;
    logic       fp_out, oof, par;

    always #(CLK_PERIOD/2) clk = ~clk;

    sonet_lane_framer #(.FRAME_LEN(FLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .frame_in(frame_in),
        .fp_sel(fp_sel), .par_sel(par_sel),
        .dout(dout), .fp_out(fp_out), .oof(oof), .par(par)
    );

    typedef struct {
        logic [7:0] d;
        logic       fp;
        logic       oof;
        logic       par;
        string      req;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R2";

    // requirement-level reference state
    logic [7:0] m_prev;
    bit         m_lock;
    int         m_miss;
    int         m_pos;

    task automatic model_reset();
        m_prev = 8'h00; m_lock = 0; m_miss = 0; m_pos = 0;
        q.delete();
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; din = 8'h00; frame_in = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        checks++;
        if (dout !== 8'h00 || fp_out !== 1'b0 || oof !== 1'b1 || par !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: got d=%h fp=%b oof=%b par=%b exp d=00 fp=0 oof=1 par=0",
                     dout, fp_out, oof, par);
        end
        rst_n = 1'b1;
    endtask

    // entered and left at a falling edge
    task automatic drive_byte(input logic [7:0] b, input logic fr);
        exp_t e;
        bit   match;
        bit   fp_i;
        int   cur;
        din = b; frame_in = fr;
        @(posedge clk);
        match = (m_prev == A1) && (b == A2);
        fp_i  = 0;
        if (!m_lock) begin
            if (match) begin m_lock = 1; m_miss = 0; m_pos = 1; end
        end else begin
            cur = m_pos;
            fp_i = (cur == 2);
            if (cur == 0) begin
                if (match) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss == 4) begin m_lock = 0; m_miss = 0; end
                end
            end
            m_pos = (cur == FLEN-1) ? 0 : cur + 1;
        end
        m_prev = b;
        e.d   = b;
        e.fp  = fp_sel ? fp_i : fr;
        e.oof = !m_lock;
        e.par = (^b) ^ (par_sel & e.fp);
        e.req = cur_req;
        q.push_back(e);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dout !== e.d || fp_out !== e.fp || oof !== e.oof || par !== e.par) begin
                fails++;
                $display("FAIL %s: got d=%h fp=%b oof=%b par=%b exp d=%h fp=%b oof=%b par=%b",
                         e.req, dout, fp_out, oof, par, e.d, e.fp, e.oof, e.par);
            end
        end
    end

    function automatic logic [7:0] filler();
        logic [7:0] v;
        v = 8'($urandom);
        if (v == A1) v = 8'hF7;
        if (v == A2) v = 8'h29;
        return v;
    endfunction

    task automatic send_fill(input int n, input int ext_every);
        for (int i = 0; i < n; i++)
            drive_byte(filler(), (ext_every > 0) && (i % ext_every == 0));
    endtask

    task automatic send_a1(input int n);
        for (int i = 0; i < n; i++) drive_byte(A1, 1'b0);
    endtask

    // index 0..2 = A2, last three = A1, others filler
    task automatic send_frame(input bit bad_a2, input bit stray, input int ext_at);
        for (int idx = 0; idx < FLEN; idx++) begin
            logic [7:0] b;
            if (idx < 3)              b = A2;
            else if (idx >= FLEN - 3) b = A1;
            else                      b = filler();
            if (bad_a2 && idx == 0) b = 8'h29;
            if (stray && idx == 10) b = A1;
            if (stray && idx == 11) b = A2;
            drive_byte(b, idx == ext_at);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        fp_sel = 1'b1; par_sel = 1'b0;
        do_reset();                                   // R1
        @(negedge clk);
        cur_req = "R2"; send_fill(9, 0);              // no marker: stays out of frame
        cur_req = "R3"; send_a1(3); send_frame(0, 0, -1);
        cur_req = "R4"; send_frame(0, 0, -1); send_frame(0, 0, -1);
        cur_req = "R6"; send_frame(0, 1, -1); send_frame(0, 0, -1);
        cur_req = "R7";
        for (int k = 0; k < 3; k++) send_frame(1, 0, -1);
        send_frame(0, 0, -1);                         // clears the miss count
        for (int k = 0; k < 4; k++) send_frame(1, 0, -1);
        cur_req = "R9"; send_fill(7, 0); send_a1(3);
        send_frame(0, 0, -1); send_frame(0, 0, -1);

        par_sel = 1'b1;
        do_reset();
        @(negedge clk);
        cur_req = "R8"; send_fill(5, 0); send_a1(3);
        send_frame(0, 0, -1); send_frame(0, 0, -1); send_frame(0, 0, -1);

        fp_sel = 1'b0;
        do_reset();
        @(negedge clk);
        cur_req = "R5"; send_fill(20, 3); send_a1(3);
        send_frame(0, 0, 7); send_frame(0, 0, 15); send_frame(0, 0, -1);

        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule